// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable synchronous SRAM core for a bus with no dead cycles between reads and writes. Every operation is captured on one rising clock edge. This includes its address, its read/write choice, its byte-write mask, its chip selects and its load/advance control. The data for that operation moves two edges later. Reads and writes use the same two-edge delay, so any sequence of reads and writes can be issued on consecutive cycles without idle gaps on the data bus.

A load starts a new operation and also opens a four-word burst. Each advance cycle that follows issues the next word of the burst, in either linear or interleaved order. An active-low clock enable freezes the whole block, including operations already in the pipeline. The data bus is split into an input port, an output port and an output-drive flag, so there is no tristate. The output-drive flag is gated without a clock by an active-low output enable.

Top module: `zbt_sram`

## Requirements
- R1: An operation issued at clock edge E0 has its data phase at edge E2. For a read, `rdata` holds the word and `rdata_oe` is high from E2 until the next enabled edge. For a write, `wdata` is sampled at E2.
- R2: Reads and writes may alternate on consecutive cycles with no idle cycles. A read issued on the cycle after a write to the same address returns the newly written word.
- R3: On a load cycle, `rd` = 1 issues a read and `rd` = 0 issues a write.
- R4: While `cke_n` is high, every input is ignored and all state holds. This covers the pipeline stages, the burst state, the array, `rdata` and the drive flag.
- R5: A load is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. If any one of these is not asserted, the load is a deselect: nothing is written, nothing is driven, and any open burst ends.
- R6: With `interleave`=0 captured at the load, the k-th advance (k = 1, 2, 3, 4, ...) issues the address whose two low bits are (base + k) mod 4. The upper address bits stay equal to the base.
- R7: With `interleave`=1 captured at the load, the k-th advance issues the address whose two low bits are base XOR (k mod 4). The upper address bits stay equal to the base.
- R8: `byte_wr_n` is captured with the address and is active low. When bit i is 0, byte i of the word, which is `wdata[8i+7:8i]`, is written. When bit i is 1, that byte keeps its old value.
- R9: `rdata_oe` falls as soon as `oe_n` goes high, without waiting for a clock edge. It rises again when `oe_n` returns low during a read data phase.
- R10: `rdata_oe` is high only in the data phase of a read. It is low during write data phases and during deselect cycles.
- R11: An advance cycle issues nothing, and behaves as a deselect, when no burst is open. This includes advances after a deselect. A burst wraps within its four-word group after the fourth word.
- R12: After reset, `rdata_oe` is low, `rdata` is zero, no operation is pending and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low loads a new operation; high advances the open burst |
| rd | input | 1 | 1 read, 0 write, sampled on load |
| interleave | input | 1 | Burst order captured on load: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| byte_wr_n | input | NB | Active-low byte-write mask |
| wdata | input | NB*8 | Write data, sampled in the write data phase |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | NB*8 | Read data |
| rdata_oe | output | 1 | Read data drive flag |

## Verification
A wrong pipeline stage or a wrong burst counter appears at the ports two edges after the faulty issue, either as a misplaced `rdata_oe` pulse or as the wrong word. The bench therefore compares the drive flag on every cycle and the data on every read phase. If a write goes to the wrong address or the wrong bytes, or if a write that should have been dropped (stalled, deselected, or an idle advance) is committed, nothing shows until that word is read. For this reason each sweep is followed by reads of the touched addresses. A stall that leaks shows up in the very next sample, because the frozen output must not move.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              load_n,
  input  logic              rd,
  input  logic              interleave,
  input  logic [AW-1:0]     addr,
  input  logic [NB-1:0]     byte_wr_n,
  input  logic [NB*BW-1:0]  wdata,
  input  logic              oe_n,
  output logic [NB*BW-1:0]  rdata,
  output logic              rdata_oe
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          bact, brd, bmode;
  logic [AW-1:0] base;
  logic [1:0]    bcnt;

  logic          v1, rd1, v2, rd2, drive_q;
  logic [AW-1:0] a1, a2;
  logic [NB-1:0] bw1, bw2;

  wire        chip_on = !sel0_n && sel1 && !sel2_n;
  wire [1:0]  nxt_k   = bcnt + 2'd1;
  wire [1:0]  adv_low = bmode ? (base[1:0] ^ nxt_k) : (base[1:0] + nxt_k);

  wire          issue_v  = load_n ? bact : chip_on;
  wire          issue_rd = load_n ? brd  : rd;
  wire [AW-1:0] issue_a  = load_n ? {base[AW-1:2], adv_low} : addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bact <= 1'b0;
      brd  <= 1'b0;
      bmode <= 1'b0;
      base <= '0;
      bcnt <= '0;
    end else if (!cke_n) begin
      if (!load_n) begin
        bact  <= chip_on;
        base  <= addr;
        bcnt  <= 2'd0;
        brd   <= rd;
        bmode <= interleave;
      end else if (bact) begin
        bcnt <= nxt_k;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; rd1 <= 1'b0; a1 <= '0; bw1 <= '1;
      v2 <= 1'b0; rd2 <= 1'b0; a2 <= '0; bw2 <= '1;
      drive_q <= 1'b0;
      rdata   <= '0;
    end else if (!cke_n) begin
      v1  <= issue_v;
      rd1 <= issue_rd;
      a1  <= issue_a;
      bw1 <= byte_wr_n;
      v2  <= v1;
      rd2 <= rd1;
      a2  <= a1;
      bw2 <= bw1;
      drive_q <= v2 && rd2;
      if (v2 && rd2) rdata <= mem[a2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cke_n && v2 && !rd2) begin
      for (int b = 0; b < NB; b++) begin
        if (!bw2[b]) mem[a2][b*BW +: BW] <= wdata[b*BW +: BW];
      end
    end
  end

  assign rdata_oe = drive_q && !oe_n;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !load_n && chip_on && rd) ##1 !cke_n ##1 !cke_n |=> drive_q);

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(rdata) && $stable(drive_q) && $stable(v2) && $stable(a2) && $stable(bcnt));

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !load_n && !chip_on) |=> !v1 && !bact);

  p_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && load_n && bact) |=> v1 && (a1[AW-1:2] == base[AW-1:2]));

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && v2 && !rd2) |=> !drive_q);

  p_idle_adv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && load_n && !bact) |=> !v1);
endmodule

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam logic [2:0] ON  = 3'b010;
  localparam logic [2:0] OFF = 3'b110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_n = 1'b1, sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic load_n = 1'b0, rd = 1'b0, interleave = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] byte_wr_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int checks = 0, fails = 0, nt = 0;

  logic [DW-1:0] mmem [1 << AW];
  logic          m_v1 = 0, m_rd1 = 0, m_v2 = 0, m_rd2 = 0;
  logic [AW-1:0] m_a1 = '0, m_a2 = '0;
  logic [NB-1:0] m_bw1 = '1, m_bw2 = '1;
  logic          bb_act = 0, bb_rd = 0, bb_mode = 0;
  logic [AW-1:0] bb_base = '0;
  int            bb_k = 0;
  logic          exp_drv = 0;
  logic [DW-1:0] exp_dat = '0;

  always #10 clk = ~clk;

  zbt_sram #(.AW(AW), .NB(NB), .BW(BW)) u_zbt_sram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .load_n(load_n), .rd(rd), .interleave(interleave),
    .addr(addr), .byte_wr_n(byte_wr_n), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rdata_oe(rdata_oe));

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input string tag, input logic ck, input logic ld, input logic [2:0] s,
                      input logic r, input logic [AW-1:0] a, input logic [NB-1:0] bw, input logic md);
    logic iv, ir;
    logic [AW-1:0] ia;
    logic [1:0] lo;
    cke_n = ck; load_n = ld; {sel0_n, sel1, sel2_n} = s; rd = r; addr = a;
    byte_wr_n = bw; interleave = md;
    wdata = DW'(32'h9E3779B1 * (nt + 1));
    nt++;
    if (!ck) begin
      iv = 0; ir = 0; ia = '0;
      if (!ld) begin
        iv = (s == ON); ir = r; ia = a;
        bb_act = (s == ON); bb_base = a; bb_k = 0; bb_rd = r; bb_mode = md;
      end else if (bb_act) begin
        bb_k++;
        lo = bb_mode ? (bb_base[1:0] ^ 2'(bb_k)) : 2'(bb_base[1:0] + bb_k);
        iv = 1; ir = bb_rd; ia = {bb_base[AW-1:2], lo};
      end
      if (m_v2 && !m_rd2)
        for (int b = 0; b < NB; b++)
          if (!m_bw2[b]) mmem[m_a2][b*BW +: BW] = wdata[b*BW +: BW];
      exp_drv = m_v2 && m_rd2;
      if (exp_drv) exp_dat = mmem[m_a2];
      m_v2 = m_v1; m_rd2 = m_rd1; m_a2 = m_a1; m_bw2 = m_bw1;
      m_v1 = iv; m_rd1 = ir; m_a1 = ia; m_bw1 = bw;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, DW'(rdata_oe), DW'(exp_drv && !oe_n));
    if (exp_drv && !oe_n) check(tag, rdata, exp_dat);
  endtask

  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [NB-1:0] bw);
    tick(tag, 0, 0, ON, 0, a, bw, 0);
  endtask
  task automatic rdop(input string tag, input logic [AW-1:0] a);
    tick(tag, 0, 0, ON, 1, a, '1, 0);
  endtask
  task automatic nop(input string tag);
    tick(tag, 0, 0, OFF, 0, '0, '1, 0);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R12", DW'(rdata_oe), '0);
    check("R12", rdata, '0);
    nop("R12"); nop("R12"); nop("R12");

    for (int a = 0; a < (1 << AW); a++) wr("R3", AW'(a), '0);
    nop("R10"); nop("R10");
    for (int a = 0; a < (1 << AW); a++) rdop("R1", AW'(a));
    nop("R1"); nop("R1");

    for (int i = 0; i < 32; i++) begin
      wr("R2", AW'(i * 3), '0);
      rdop("R2", AW'(i * 3));
    end
    for (int i = 0; i < 16; i++) begin
      rdop("R2", AW'(i));
      wr("R2", AW'(i + 40), '0);
    end
    nop("R2"); nop("R2");

    for (int m = 0; m < (1 << NB); m++) begin
      wr("R8", 6'd5, NB'(m));
      rdop("R8", 6'd5);
      nop("R8");
    end
    nop("R8"); nop("R8");

    rdop("R4", 6'd7);
    wr("R4", 6'd8, '0);
    for (int i = 0; i < 4; i++) tick("R4", 1, 0, ON, 0, 6'd7, '0, 0);
    nop("R4");
    for (int i = 0; i < 3; i++) tick("R4", 1, 1, ON, 1, 6'd8, '0, 1);
    nop("R4"); nop("R4");
    rdop("R4", 6'd7); rdop("R4", 6'd8);
    nop("R4"); nop("R4");

    tick("R5", 0, 0, 3'b110, 0, 6'd9, '0, 0);
    tick("R5", 0, 0, 3'b000, 0, 6'd10, '0, 0);
    tick("R5", 0, 0, 3'b011, 0, 6'd11, '0, 0);
    tick("R5", 0, 0, 3'b011, 1, 6'd9, '1, 0);
    nop("R10"); nop("R10");
    rdop("R5", 6'd9); rdop("R5", 6'd10); rdop("R5", 6'd11);
    nop("R5"); nop("R5");

    for (int md = 0; md < 2; md++)
      for (int b = 0; b < 4; b++) begin
        tick(md ? "R7" : "R6", 0, 0, ON, 0, AW'(16 + 4 * b + b), '0, md[0]);
        for (int k = 0; k < 3; k++) tick(md ? "R7" : "R6", 0, 1, ON, 0, '0, NB'(k), md[0]);
        tick(md ? "R7" : "R6", 0, 0, ON, 1, AW'(16 + 4 * b + b), '1, md[0]);
        for (int k = 0; k < 6; k++) tick(md ? "R7" : "R11", 0, 1, ON, 0, '0, '1, md[0]);
        nop("R6"); nop("R6");
      end

    nop("R11");
    for (int i = 0; i < 3; i++) tick("R11", 0, 1, ON, 0, 6'd2, '0, 0);
    rdop("R11", 6'd12);
    tick("R11", 0, 1, OFF, 0, '0, '1, 0);
    tick("R11", 0, 0, OFF, 0, '0, '1, 0);
    tick("R11", 0, 1, ON, 0, 6'd2, '0, 0);
    tick("R11", 0, 1, ON, 0, 6'd2, '0, 0);
    nop("R11"); nop("R11");
    for (int a = 0; a < 16; a++) rdop("R11", AW'(a));
    nop("R11"); nop("R11");

    rdop("R9", 6'd3);
    nop("R9"); nop("R9");
    oe_n = 1'b1;
    #1 check("R9", DW'(rdata_oe), '0);
    oe_n = 1'b0;
    #1 check("R9", DW'(rdata_oe), DW'(1));
    #1 check("R9", rdata, mmem[3]);
    @(negedge clk);
    nop("R9"); nop("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule